// File: doc/BRIEF.md
# Two-Bank Level Interrupt Aggregator

This block gathers a 64-wide bank of peripheral interrupt lines and an 8-wide bank of local interrupt lines, all level-sensitive, into one normal interrupt request and one fast interrupt request. Each line has its own enable bit. Enables are changed through write-one-to-set and write-one-to-clear registers, so software never needs a read-modify-write sequence. Nothing is latched. Every pending view is the live input level ANDed with its enable, so a source drops out of every view as soon as it deasserts.

A 32-bit register port with separate read and write strobes gives access to the enables, the masked pending words and a summary word. The summary word folds the local sources, one "anything pending" flag for each peripheral half, and copies of eleven frequently used peripheral sources into a single read. A 7-bit selector plus an enable route one source from either bank straight to the fast request. That path bypasses the normal enables. Both requests are registered.

Top module: `irq_fold_ctrl`

## Requirements
- R1: After reset all peripheral enables, all local enables, the fast-request select and the fast-request enable are zero, and both request outputs are low.
- R2: A write to a set register (0x10 for peripherals 0-31, 0x14 for 32-63, 0x18 for local) ORs the data into the enables. A write to a clear register (0x1C, 0x20, 0x24 for the same groups) clears every enable whose data bit is 1. Only data bits 7:0 affect the local group.
- R3: Reading a set register returns the enables of its group in the low bits, with zeros above. Reading the matching clear register returns the bitwise inverse of that whole 32-bit word, so the unused upper bits of the local clear view read as 1.
- R4: Offset 0x04 reads peripheral lines 0-31 ANDed with their enables, and offset 0x08 does the same for lines 32-63. Both views follow the live levels with no latching.
- R5: In the summary word (offset 0x00), bits 7:0 are the local lines ANDed with the local enables. Bit 8 is set when any of peripheral lines 0-31 is enabled and active. Bit 9 does the same for lines 32-63. Bits 31:21 read zero.
- R6: Summary bits 10 up to 20 carry the enabled-and-active state of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order.
- R7: The fast-request control register (0x0C) stores a select in bits 6:0 and an enable in bit 7. It reads back in that layout with zeros above, and write data above bit 7 is ignored.
- R8: While the fast-request enable is set, the fast request follows the raw level of the selected line. Selects 0-63 pick a peripheral line, 64-71 pick local line (select-64), and 72-127 give low. The normal enables have no effect on this path. With the enable clear the output is low.
- R9: The normal request is high exactly when at least one line in either bank is both active and enabled.
- R10: Both request outputs are registered. They change on the first clock edge after the input or register change that causes them.
- R11: Reads of unmapped or misaligned offsets return zero. Writes to them, and writes to the read-only offsets 0x00-0x08, change nothing. Read data is zero while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| periph_in | input | 64 | Peripheral interrupt levels |
| local_in | input | 8 | Local interrupt levels |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The bench first writes ones to the clear registers and reads them back before anything is enabled. A design that stored the written value would return the data instead of the inverted enables, and a design that cut the local clear view to 8 bits would return zeros in the upper bits. It steps the fast-request select across the boundaries 62, 63, 64, 65, 71 and 72. An off-by-one in the bank split would route the wrong line, and an out-of-range select that wrapped would report a live local line. The shortcut copies in the summary word are checked at both ends of the list, so a reversed or shifted order shows up in the wrong bit. The bench also counts the edges between an enable write and the request, so an unregistered output or an extra pipeline stage is caught.

// File: rtl/irq_fold_pkg.sv
package irq_fold_pkg;

   localparam int OFS_W = 8;

   localparam logic [OFS_W-1:0] OFS_SUMMARY  = 8'h00;
   localparam logic [OFS_W-1:0] OFS_PEND_LO  = 8'h04;
   localparam logic [OFS_W-1:0] OFS_PEND_HI  = 8'h08;
   localparam logic [OFS_W-1:0] OFS_FIQ_CTRL = 8'h0C;
   localparam logic [OFS_W-1:0] OFS_SET_LO   = 8'h10;
   localparam logic [OFS_W-1:0] OFS_SET_HI   = 8'h14;
   localparam logic [OFS_W-1:0] OFS_SET_LOC  = 8'h18;
   localparam logic [OFS_W-1:0] OFS_CLR_LO   = 8'h1C;
   localparam logic [OFS_W-1:0] OFS_CLR_HI   = 8'h20;
   localparam logic [OFS_W-1:0] OFS_CLR_LOC  = 8'h24;

   // summary word layout: fixed because software decodes it
   localparam int SUM_ANY_LO_BIT = 8;
   localparam int SUM_ANY_HI_BIT = 9;
   localparam int SUM_SHORT_LSB  = 10;
   localparam int NUM_SHORT      = 11;
   localparam int MAX_SHORT_SRC  = 62;

   // peripheral line copied into summary bit SUM_SHORT_LSB+idx
   function automatic int shortcut_src(input int idx);
      case (idx)
         0:       return 7;
         1:       return 9;
         2:       return 10;
         3:       return 18;
         4:       return 19;
         5:       return 53;
         6:       return 54;
         7:       return 55;
         8:       return 56;
         9:       return 57;
         10:      return 62;
         default: return 0;
      endcase
   endfunction

   typedef struct packed {
      logic summary;
      logic pend_lo;
      logic pend_hi;
      logic fiq_ctrl;
      logic set_lo;
      logic set_hi;
      logic set_loc;
      logic clr_lo;
      logic clr_hi;
      logic clr_loc;
   } reg_hit_t;

endpackage

// File: rtl/irq_fold_enables.sv
module irq_fold_enables #(
   parameter int DATA_W  = 32,
   parameter int LOCAL_N = 8,
   parameter int BANKS   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [BANKS-1:0]          set_bank,
   input  logic [BANKS-1:0]          clr_bank,
   input  logic                      set_loc,
   input  logic                      clr_loc,
   input  logic [DATA_W-1:0]         wdata,
   output logic [BANKS*DATA_W-1:0]   periph_en,
   output logic [LOCAL_N-1:0]        local_en
);

   logic [DATA_W-1:0]  bank_q [BANKS];
   logic [LOCAL_N-1:0] loc_q;

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_q[b] <= '0;
         end else if (set_bank[b]) begin
            bank_q[b] <= bank_q[b] | wdata;
         end else if (clr_bank[b]) begin
            bank_q[b] <= bank_q[b] & ~wdata;
         end
      end
      assign periph_en[b*DATA_W +: DATA_W] = bank_q[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc_q <= '0;
      end else if (set_loc) begin
         loc_q <= loc_q | wdata[LOCAL_N-1:0];
      end else if (clr_loc) begin
         loc_q <= loc_q & ~wdata[LOCAL_N-1:0];
      end
   end

   assign local_en = loc_q;

endmodule

// File: rtl/irq_fold_summary.sv
module irq_fold_summary
   import irq_fold_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int PERIPH_N = 64,
   parameter int LOCAL_N  = 8
) (
   input  logic [PERIPH_N-1:0] periph_in,
   input  logic [PERIPH_N-1:0] periph_en,
   input  logic [LOCAL_N-1:0]  local_in,
   input  logic [LOCAL_N-1:0]  local_en,
   output logic [DATA_W-1:0]   pend_lo,
   output logic [DATA_W-1:0]   pend_hi,
   output logic [DATA_W-1:0]   summary,
   output logic                irq_any
);

   logic [PERIPH_N-1:0] pend;
   logic [LOCAL_N-1:0]  lpend;

   assign pend    = periph_in & periph_en;
   assign lpend   = local_in & local_en;
   assign pend_lo = pend[DATA_W-1:0];
   assign pend_hi = pend[PERIPH_N-1:DATA_W];
   assign irq_any = (|pend) | (|lpend);

   always_comb begin
      summary                  = '0;
      summary[LOCAL_N-1:0]     = lpend;
      summary[SUM_ANY_LO_BIT]  = |pend_lo;
      summary[SUM_ANY_HI_BIT]  = |pend_hi;
      for (int i = 0; i < NUM_SHORT; i++) begin
         summary[SUM_SHORT_LSB+i] = pend[shortcut_src(i)];
      end
   end

endmodule

// File: rtl/irq_fold_fiq.sv
module irq_fold_fiq #(
   parameter int PERIPH_N = 64,
   parameter int LOCAL_N  = 8,
   parameter int SEL_W    = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctrl_wr,
   input  logic [SEL_W:0]      ctrl_wdata,
   input  logic [PERIPH_N-1:0] periph_in,
   input  logic [LOCAL_N-1:0]  local_in,
   output logic [SEL_W:0]      fiq_ctrl,
   output logic                fiq_out
);

   localparam int SRC_SPAN = 2 ** SEL_W;

   logic [SEL_W-1:0]    sel_q;
   logic                en_q;
   logic [SRC_SPAN-1:0] src_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         en_q  <= 1'b0;
      end else if (ctrl_wr) begin
         sel_q <= ctrl_wdata[SEL_W-1:0];
         en_q  <= ctrl_wdata[SEL_W];
      end
   end

   // selects beyond the local bank land on constant zero
   always_comb begin
      src_all                    = '0;
      src_all[PERIPH_N-1:0]      = periph_in;
      src_all[PERIPH_N +: LOCAL_N] = local_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fiq_out <= 1'b0;
      end else begin
         fiq_out <= en_q & src_all[sel_q];
      end
   end

   assign fiq_ctrl = {en_q, sel_q};

endmodule

// File: rtl/irq_fold_ctrl.sv
module irq_fold_ctrl
   import irq_fold_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int PERIPH_N  = 64,
   parameter int LOCAL_N   = 8,
   parameter int FIQ_SEL_W = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [PERIPH_N-1:0] periph_in,
   input  logic [LOCAL_N-1:0]  local_in,
   output logic                irq_out,
   output logic                fiq_out
);

   localparam int BANKS = PERIPH_N / DATA_W;

   initial begin
      assert (PERIPH_N == 2 * DATA_W)
         else $error("peripheral bank must be exactly two data words");
      assert (LOCAL_N >= 1 && LOCAL_N <= SUM_ANY_LO_BIT)
         else $error("local bank must fit below the summary flags");
      assert (PERIPH_N + LOCAL_N <= 2 ** FIQ_SEL_W)
         else $error("fast-request select too narrow for both banks");
      assert (FIQ_SEL_W + 1 <= DATA_W)
         else $error("fast-request control wider than a data word");
      assert (SUM_SHORT_LSB + NUM_SHORT <= DATA_W && MAX_SHORT_SRC < PERIPH_N)
         else $error("shortcut list does not fit");
      assert (ADDR_W >= OFS_W)
         else $error("address too narrow for register map");
   end

   reg_hit_t            hit;
   logic [PERIPH_N-1:0] periph_en;
   logic [LOCAL_N-1:0]  local_en;
   logic [FIQ_SEL_W:0]  fiq_ctrl;
   logic [DATA_W-1:0]   pend_lo;
   logic [DATA_W-1:0]   pend_hi;
   logic [DATA_W-1:0]   summary;
   logic                irq_any;
   logic [DATA_W-1:0]   rdata_c;
   logic [DATA_W-1:0]   loc_word;
   logic [DATA_W-1:0]   fiq_word;

   always_comb begin
      hit          = '0;
      hit.summary  = (bus_addr == ADDR_W'(OFS_SUMMARY));
      hit.pend_lo  = (bus_addr == ADDR_W'(OFS_PEND_LO));
      hit.pend_hi  = (bus_addr == ADDR_W'(OFS_PEND_HI));
      hit.fiq_ctrl = (bus_addr == ADDR_W'(OFS_FIQ_CTRL));
      hit.set_lo   = (bus_addr == ADDR_W'(OFS_SET_LO));
      hit.set_hi   = (bus_addr == ADDR_W'(OFS_SET_HI));
      hit.set_loc  = (bus_addr == ADDR_W'(OFS_SET_LOC));
      hit.clr_lo   = (bus_addr == ADDR_W'(OFS_CLR_LO));
      hit.clr_hi   = (bus_addr == ADDR_W'(OFS_CLR_HI));
      hit.clr_loc  = (bus_addr == ADDR_W'(OFS_CLR_LOC));
   end

   irq_fold_enables #(
      .DATA_W  (DATA_W),
      .LOCAL_N (LOCAL_N),
      .BANKS   (BANKS)
   ) u_enables (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_bank  ({bus_wr & hit.set_hi, bus_wr & hit.set_lo}),
      .clr_bank  ({bus_wr & hit.clr_hi, bus_wr & hit.clr_lo}),
      .set_loc   (bus_wr & hit.set_loc),
      .clr_loc   (bus_wr & hit.clr_loc),
      .wdata     (bus_wdata),
      .periph_en (periph_en),
      .local_en  (local_en)
   );

   irq_fold_summary #(
      .DATA_W   (DATA_W),
      .PERIPH_N (PERIPH_N),
      .LOCAL_N  (LOCAL_N)
   ) u_summary (
      .periph_in (periph_in),
      .periph_en (periph_en),
      .local_in  (local_in),
      .local_en  (local_en),
      .pend_lo   (pend_lo),
      .pend_hi   (pend_hi),
      .summary   (summary),
      .irq_any   (irq_any)
   );

   irq_fold_fiq #(
      .PERIPH_N (PERIPH_N),
      .LOCAL_N  (LOCAL_N),
      .SEL_W    (FIQ_SEL_W)
   ) u_fiq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_wr    (bus_wr & hit.fiq_ctrl),
      .ctrl_wdata (bus_wdata[FIQ_SEL_W:0]),
      .periph_in  (periph_in),
      .local_in   (local_in),
      .fiq_ctrl   (fiq_ctrl),
      .fiq_out    (fiq_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_out <= 1'b0;
      end else begin
         irq_out <= irq_any;
      end
   end

   assign loc_word = {{(DATA_W-LOCAL_N){1'b0}}, local_en};
   assign fiq_word = {{(DATA_W-FIQ_SEL_W-1){1'b0}}, fiq_ctrl};

   always_comb begin
      rdata_c = '0;
      if (bus_rd) begin
         unique case (1'b1)
            hit.summary:  rdata_c = summary;
            hit.pend_lo:  rdata_c = pend_lo;
            hit.pend_hi:  rdata_c = pend_hi;
            hit.fiq_ctrl: rdata_c = fiq_word;
            hit.set_lo:   rdata_c = periph_en[DATA_W-1:0];
            hit.set_hi:   rdata_c = periph_en[PERIPH_N-1:DATA_W];
            hit.set_loc:  rdata_c = loc_word;
            hit.clr_lo:   rdata_c = ~periph_en[DATA_W-1:0];
            hit.clr_hi:   rdata_c = ~periph_en[PERIPH_N-1:DATA_W];
            hit.clr_loc:  rdata_c = ~loc_word;
            default:      rdata_c = '0;
         endcase
      end
   end

   assign bus_rdata = rdata_c;

endmodule

// File: rtl/irq_fold_checker.sv
module irq_fold_checker
   import irq_fold_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int PERIPH_N  = 64,
   parameter int LOCAL_N   = 8,
   parameter int FIQ_SEL_W = 7
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [PERIPH_N-1:0] periph_in,
   input logic [LOCAL_N-1:0]  local_in,
   input logic                irq_out,
   input logic                fiq_out,
   input logic [PERIPH_N-1:0] periph_en,
   input logic [LOCAL_N-1:0]  local_en,
   input logic [FIQ_SEL_W:0]  fiq_ctrl
);

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!irq_out && !fiq_out && periph_en == '0 && local_en == '0 && fiq_ctrl == '0)); // R1

   AST_SET_ORS_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_SET_LO)) |=>
      ((periph_en[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata))); // R2

   AST_CLR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_CLR_LO)) |=>
      ((periph_en[DATA_W-1:0] & $past(bus_wdata)) == '0)); // R2

   AST_CLR_VIEW_INV: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OFS_CLR_HI)) |->
      (bus_rdata == ~periph_en[PERIPH_N-1:DATA_W])); // R3

   AST_SUM_LOCAL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OFS_SUMMARY)) |->
      ((bus_rdata[LOCAL_N-1:0] & ~(local_in & local_en)) == '0)); // R5

   AST_FIQ_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OFS_FIQ_CTRL)) |->
      (bus_rdata == DATA_W'(fiq_ctrl))); // R7

   AST_FIQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_out |-> $past(fiq_ctrl[FIQ_SEL_W])); // R8

   AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past((|periph_in) || (|local_in))); // R9

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past((|periph_en) || (|local_en))); // R10

   AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0)); // R11

endmodule

bind irq_fold_ctrl irq_fold_checker #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .PERIPH_N  (PERIPH_N),
   .LOCAL_N   (LOCAL_N),
   .FIQ_SEL_W (FIQ_SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .periph_in (periph_in),
   .local_in  (local_in),
   .irq_out   (irq_out),
   .fiq_out   (fiq_out),
   .periph_en (periph_en),
   .local_en  (local_en),
   .fiq_ctrl  (fiq_ctrl)
);

// File: tb/irq_fold_ctrl_test.sv
`timescale 1ns/1ps
module irq_fold_ctrl_test;

   typedef struct packed {
      logic [1:0]  op;     // 0 write, 1 read-check, 2 drive inputs, 3 output-check
      logic [7:0]  addr;
      logic [63:0] dat;    // write data, or peripheral levels for op 2
      logic [31:0] exp;    // expected read / {irq,fiq} / local levels for op 2
      logic [3:0]  req;
   } vec_t;

   localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OIN = 2'd2, OOUT = 2'd3;
   localparam logic [63:0] PIN = 64'h4000_0000_0000_0280; // lines 7, 9, 62

   localparam int NV = 57;
   localparam vec_t VECS [NV] = '{
      '{ORD, 8'h10, 64'h0, 32'h0000_0000, 4'd1},  // R1 enables cleared
      '{ORD, 8'h1C, 64'h0, 32'hFFFF_FFFF, 4'd3},  // R3 clear view inverted
      '{ORD, 8'h24, 64'h0, 32'hFFFF_FFFF, 4'd3},  // R3 local clear view full width
      '{ORD, 8'h0C, 64'h0, 32'h0000_0000, 4'd1},  // R1 fast control cleared
      '{OIN, 8'h00, PIN,   32'h0000_0005, 4'd9},
      '{OOUT,8'h00, 64'h0, 32'h0000_0000, 4'd9},  // R9 nothing enabled
      '{ORD, 8'h04, 64'h0, 32'h0000_0000, 4'd4},  // R4
      '{OW,  8'h10, 64'h280, 32'h0,       4'd2},  // R2 set
      '{OW,  8'h10, 64'h001, 32'h0,       4'd2},  // R2 set ORs
      '{ORD, 8'h10, 64'h0, 32'h0000_0281, 4'd2},  // R2
      '{ORD, 8'h1C, 64'h0, 32'hFFFF_FD7E, 4'd3},  // R3
      '{OOUT,8'h00, 64'h0, 32'h0000_0002, 4'd9},  // R9 irq high
      '{ORD, 8'h04, 64'h0, 32'h0000_0280, 4'd4},  // R4 masked
      '{ORD, 8'h00, 64'h0, 32'h0000_0D00, 4'd6},  // R6 first shortcuts, R5 bit 8
      '{OW,  8'h14, 64'h4000_0000, 32'h0, 4'd2},
      '{ORD, 8'h08, 64'h0, 32'h4000_0000, 4'd4},  // R4 high half
      '{ORD, 8'h00, 64'h0, 32'h0010_0F00, 4'd6},  // R6 last shortcut bit 20
      '{OW,  8'h18, 64'hFFFF_FF0F, 32'h0, 4'd2},  // R2 only low 8 bits
      '{ORD, 8'h18, 64'h0, 32'h0000_000F, 4'd2},  // R2
      '{ORD, 8'h24, 64'h0, 32'hFFFF_FFF0, 4'd3},  // R3
      '{ORD, 8'h00, 64'h0, 32'h0010_0F05, 4'd5},  // R5 local bits
      '{OW,  8'h24, 64'h01, 32'h0,        4'd2},  // R2 clear
      '{ORD, 8'h00, 64'h0, 32'h0010_0F04, 4'd5},  // R5
      '{OW,  8'h1C, 64'hFFFF_FFFF, 32'h0, 4'd2},
      '{ORD, 8'h04, 64'h0, 32'h0000_0000, 4'd2},  // R2 clear all low
      '{ORD, 8'h00, 64'h0, 32'h0010_0204, 4'd5},  // R5 bit 8 low, bit 9 high
      '{OW,  8'h20, 64'hFFFF_FFFF, 32'h0, 4'd2},
      '{OW,  8'h24, 64'hFF, 32'h0,        4'd2},
      '{OOUT,8'h00, 64'h0, 32'h0000_0000, 4'd9},  // R9 active but disabled
      '{OW,  8'h0C, 64'hFFFF_FF09, 32'h0, 4'd7},
      '{ORD, 8'h0C, 64'h0, 32'h0000_0009, 4'd7},  // R7 upper data ignored
      '{OOUT,8'h00, 64'h0, 32'h0000_0000, 4'd8},  // R8 disabled
      '{OW,  8'h0C, 64'h89, 32'h0,        4'd8},
      '{ORD, 8'h0C, 64'h0, 32'h0000_0089, 4'd7},  // R7
      '{OOUT,8'h00, 64'h0, 32'h0000_0001, 4'd8},  // R8 line 9, no irq enables
      '{OW,  8'h0C, 64'hBE, 32'h0,        4'd8},
      '{OOUT,8'h00, 64'h0, 32'h0000_0001, 4'd8},  // R8 select 62
      '{OW,  8'h0C, 64'hBF, 32'h0,        4'd8},
      '{OOUT,8'h00, 64'h0, 32'h0000_0000, 4'd8},  // R8 select 63 idle
      '{OW,  8'h0C, 64'hC0, 32'h0,        4'd8},
      '{OOUT,8'h00, 64'h0, 32'h0000_0001, 4'd8},  // R8 select 64 -> local 0
      '{OW,  8'h0C, 64'hC1, 32'h0,        4'd8},
      '{OOUT,8'h00, 64'h0, 32'h0000_0000, 4'd8},  // R8 local 1 idle
      '{OW,  8'h0C, 64'hC2, 32'h0,        4'd8},
      '{OOUT,8'h00, 64'h0, 32'h0000_0001, 4'd8},  // R8 local 2
      '{OIN, 8'h00, PIN,   32'h0000_00FF, 4'd8},
      '{OW,  8'h0C, 64'hC8, 32'h0,        4'd8},
      '{OOUT,8'h00, 64'h0, 32'h0000_0000, 4'd8},  // R8 select 72 out of range
      '{OW,  8'h0C, 64'hC7, 32'h0,        4'd8},
      '{OOUT,8'h00, 64'h0, 32'h0000_0001, 4'd8},  // R8 select 71 -> local 7
      '{ORD, 8'h00, 64'h0, 32'h0000_0000, 4'd5},  // R5 all locals masked
      '{OW,  8'h28, 64'hFFFF_FFFF, 32'h0, 4'd11}, // R11 unmapped write
      '{OW,  8'h00, 64'hFFFF_FFFF, 32'h0, 4'd11}, // R11 read-only write
      '{OW,  8'h08, 64'hFFFF_FFFF, 32'h0, 4'd11},
      '{ORD, 8'h10, 64'h0, 32'h0000_0000, 4'd11}, // R11 nothing changed
      '{ORD, 8'h28, 64'h0, 32'h0000_0000, 4'd11}, // R11 unmapped read
      '{ORD, 8'h11, 64'h0, 32'h0000_0000, 4'd11}  // R11 misaligned read
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  bus_addr;
   logic        bus_wr;
   logic        bus_rd;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [63:0] periph_in;
   logic [7:0]  local_in;
   logic        irq_out;
   logic        fiq_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   irq_fold_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .periph_in (periph_in),
      .local_in  (local_in),
      .irq_out   (irq_out),
      .fiq_out   (fiq_out)
   );

   task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic do_rd(input logic [7:0] a, input logic [31:0] exp, input int req);
      bus_addr = a;
      bus_rd   = 1'b1;
      #1;
      chk(req, bus_rdata, exp, $sformatf("read %h", a));
      bus_rd   = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
      bus_wdata = '0; periph_in = '0; local_in = '0;
      repeat (3) @(negedge clk);
      chk(1, {30'd0, irq_out, fiq_out}, 32'd0, "outputs in reset"); // R1
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         case (VECS[i].op)
            OW:  do_wr(VECS[i].addr, VECS[i].dat[31:0]);
            ORD: do_rd(VECS[i].addr, VECS[i].exp, int'(VECS[i].req));
            OIN: begin
               periph_in = VECS[i].dat;
               local_in  = VECS[i].exp[7:0];
               @(negedge clk);
            end
            default: begin
               @(negedge clk);
               chk(int'(VECS[i].req), {30'd0, irq_out, fiq_out}, VECS[i].exp,
                   $sformatf("outputs vector %0d", i));
            end
         endcase
      end

      // R10: count edges from enable write to request
      do_wr(8'h0C, 32'h0);
      periph_in = 64'h0; local_in = 8'h0;
      @(negedge clk);
      periph_in = 64'h8;
      @(negedge clk);
      do_wr(8'h10, 32'h8);
      #1 chk(10, {31'd0, irq_out}, 32'd0, "irq before extra edge"); // R10
      @(negedge clk);
      chk(10, {31'd0, irq_out}, 32'd1, "irq one edge after enable"); // R10
      bus_addr = 8'h10;
      #1 chk(11, bus_rdata, 32'd0, "rdata with read strobe low"); // R11
      periph_in = 64'h0;
      #1 chk(10, {31'd0, irq_out}, 32'd1, "irq holds until edge"); // R10
      @(negedge clk);
      chk(4, {31'd0, irq_out}, 32'd0, "irq drops, no latch"); // R4
      do_rd(8'h04, 32'h0, 4);  // R4 pending cleared with input
      periph_in = 64'h8;
      do_rd(8'h04, 32'h8, 4);  // R4 live level

      // R1: reset in mid-run
      do_wr(8'h0C, 32'h83);
      rst_n = 1'b0;
      @(negedge clk);
      chk(1, {30'd0, irq_out, fiq_out}, 32'd0, "outputs after reset"); // R1
      rst_n = 1'b1;
      @(negedge clk);
      do_rd(8'h10, 32'h0, 1);  // R1
      do_rd(8'h0C, 32'h0, 1);  // R1
      @(negedge clk);
      chk(1, {30'd0, irq_out, fiq_out}, 32'd0, "outputs after release"); // R1

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule